// File: doc/BRIEF.md
# Tagged Receive Queue Demultiplexer

This block sits at the receive end of a network endpoint. It takes packets from a 32-bit valid/ready word stream and sorts their payload into a set of queues that software reads. The first word of each packet is a header that gives the payload length. The second word is a tag made of the sender node id, a stream number and a message type. Neither word is stored. The tag is compared at once against one programmable tag register per tagged queue. The payload words that follow go into the queue whose tag matches.

A packet whose tag matches no register is sent to a catch-all queue. While that queue holds data, an interrupt line stays high, so software can deal with unexpected traffic and then clear the interrupt by draining it. A fixed pool of receive words is split evenly between the queues. When the target queue fills during a payload, the input is held off and no data is lost.

Top module: `tagged_rx_demux`

## Requirements
- R1: After reset, in_ready_o is high, every q_valid_o bit is low, irq_o is low and every tag register reads as zero (a packet with tag word 0 lands in queue 0).
- R2: A packet is a header word, then a tag word, then N payload words, where N is header bits [7:0] and header bits [31:8] are ignored. Neither the header nor the tag word is enqueued.
- R3: The tag word holds the sender id in [31:16], the stream number in [15:8] and the message type in [7:0]. A packet whose tag equals tag register i in all 32 bits puts its payload into queue i (i = 0..3), in arrival order. A difference in any one field makes that register miss.
- R4: When several tag registers hold the packet's tag, the lowest-numbered queue gets the payload.
- R5: A packet whose tag matches no tag register puts its payload into the catch-all queue, index 4.
- R6: irq_o is high exactly while the catch-all queue is non-empty. It goes low once software has drained that queue.
- R7: Each of the five queues holds 25 words (128 words divided by 5, rounded down). While the target queue is full during a payload, in_ready_o is low. The stalled word is accepted once a word has been popped from that queue, and no payload word is lost or reordered.
- R8: A cycle with tag_we_i high loads tag_wdata_i into tag register tag_sel_i. The new value decides the routing of every packet whose tag word arrives later.
- R9: For queue q, q_valid_o[q] is high while the queue is non-empty and q_data_o[32q+31:32q] shows its oldest word. A cycle with q_pop_i[q] high and q_valid_o[q] high removes that word.
- R10: A packet with N = 0 enqueues nothing and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 32 | Incoming stream word |
| in_valid_i | input | 1 | Stream word valid |
| in_ready_o | output | 1 | Block accepts the stream word |
| tag_we_i | input | 1 | Tag register write strobe |
| tag_sel_i | input | 2 | Tag register index |
| tag_wdata_i | input | 32 | Tag register write value |
| q_pop_i | input | 5 | Per-queue pop strobe, bit 4 is the catch-all |
| q_data_o | output | 160 | Per-queue head word, queue q in bits [32q+31:32q] |
| q_valid_o | output | 5 | Per-queue non-empty flag |
| irq_o | output | 1 | Catch-all queue holds data |

## Verification
The tag compare is tested with a set of tags chosen so that each outcome is separated from the others:
- Exact hits on distinct registers show that the routing is correct.
- A tag held by two registers shows the priority rule.
- Tags that differ from a programmed value only in the sender, only in the stream, or only in the type field show that all 32 bits take part in the compare and that each such packet goes to the catch-all queue.

Directed cases cover the following:
- A payload that overflows a queue, which checks the stall and then the resume without loss.
- Rewriting a tag, which shows that routing follows the new value.
- A zero-length packet.
- Header bits that must be ignored.

// File: rtl/trdx_pkg.sv
package trdx_pkg;
  typedef enum logic [1:0] {
    ST_HDR = 2'd0,
    ST_TAG = 2'd1,
    ST_PAY = 2'd2
  } rx_state_e;
endpackage

// File: rtl/trdx_tag_match.sv
module trdx_tag_match #(
  parameter int unsigned NUM_TAGGED = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned QIDX_W     = 3
) (
  input  logic [NUM_TAGGED-1:0][DATA_W-1:0] tags_i,
  input  logic [DATA_W-1:0]                 key_i,
  output logic [QIDX_W-1:0]                 qidx_o
);
  // scan high to low so the lowest matching index is assigned last
  always_comb begin
    qidx_o = QIDX_W'(NUM_TAGGED);
    for (int i = NUM_TAGGED - 1; i >= 0; i--) begin
      if (tags_i[i] == key_i) qidx_o = QIDX_W'(i);
    end
  end
endmodule

// File: rtl/trdx_fifo.sv
module trdx_fifo #(
  parameter int unsigned DEPTH  = 25,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              valid_o,
  output logic              full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign valid_o = (cnt_q != '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;
  assign rdata_o = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CNT_W'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end
endmodule

// File: rtl/trdx_rx_parser.sv
module trdx_rx_parser
  import trdx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned NUM_Q  = 5,
  parameter int unsigned QIDX_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [QIDX_W-1:0] match_qidx_i,
  input  logic [NUM_Q-1:0]  full_i,
  output logic [NUM_Q-1:0]  push_o,
  output rx_state_e         state_o
);
  rx_state_e         state_q;
  logic [LEN_W-1:0]  remain_q;
  logic [QIDX_W-1:0] sel_q;
  logic              accept;

  assign state_o = state_q;
  assign ready_o = (state_q != ST_PAY) || !full_i[sel_q];
  assign accept  = valid_i && ready_o;

  always_comb begin
    push_o = '0;
    if (state_q == ST_PAY && accept) push_o[sel_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HDR;
      remain_q <= '0;
      sel_q    <= '0;
    end else if (accept) begin
      unique case (state_q)
        ST_HDR: begin
          remain_q <= data_i[LEN_W-1:0];
          state_q  <= ST_TAG;
        end
        ST_TAG: begin
          sel_q   <= match_qidx_i;
          state_q <= (remain_q == '0) ? ST_HDR : ST_PAY;
        end
        ST_PAY: begin
          remain_q <= remain_q - LEN_W'(1);
          if (remain_q == LEN_W'(1)) state_q <= ST_HDR;
        end
        default: state_q <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/tagged_rx_demux.sv
module tagged_rx_demux #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_TAGGED  = 4,
  parameter int unsigned TOTAL_WORDS = 128,
  parameter int unsigned LEN_W       = 8,
  localparam int unsigned NUM_Q      = NUM_TAGGED + 1,
  localparam int unsigned Q_DEPTH    = TOTAL_WORDS / NUM_Q,
  localparam int unsigned QIDX_W     = $clog2(NUM_Q),
  localparam int unsigned TSEL_W     = (NUM_TAGGED > 1) ? $clog2(NUM_TAGGED) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DATA_W-1:0]       in_data_i,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic                    tag_we_i,
  input  logic [TSEL_W-1:0]       tag_sel_i,
  input  logic [DATA_W-1:0]       tag_wdata_i,
  input  logic [NUM_Q-1:0]        q_pop_i,
  output logic [NUM_Q*DATA_W-1:0] q_data_o,
  output logic [NUM_Q-1:0]        q_valid_o,
  output logic                    irq_o
);
  logic [NUM_TAGGED-1:0][DATA_W-1:0] tags_q;
  logic [QIDX_W-1:0]                 match_qidx;
  logic [NUM_Q-1:0]                  push, full;
  trdx_pkg::rx_state_e               parser_state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tags_q <= '0;
    else if (tag_we_i) tags_q[tag_sel_i] <= tag_wdata_i;
  end

  trdx_tag_match #(
    .NUM_TAGGED(NUM_TAGGED), .DATA_W(DATA_W), .QIDX_W(QIDX_W)
  ) u_match (
    .tags_i(tags_q), .key_i(in_data_i), .qidx_o(match_qidx)
  );

  trdx_rx_parser #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .NUM_Q(NUM_Q), .QIDX_W(QIDX_W)
  ) u_parser (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .data_i(in_data_i), .valid_i(in_valid_i), .ready_o(in_ready_o),
    .match_qidx_i(match_qidx), .full_i(full),
    .push_o(push), .state_o(parser_state)
  );

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    trdx_fifo #(.DEPTH(Q_DEPTH), .DATA_W(DATA_W)) u_fifo (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .push_i(push[g]), .wdata_i(in_data_i),
      .pop_i(q_pop_i[g]),
      .rdata_o(q_data_o[g*DATA_W +: DATA_W]),
      .valid_o(q_valid_o[g]),
      .full_o(full[g])
    );
  end

  assign irq_o = q_valid_o[NUM_Q-1];
endmodule

// File: rtl/trdx_checker.sv
module trdx_checker #(
  parameter int unsigned NUM_Q  = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [1:0]              state_i,
  input logic [NUM_Q-1:0]        push_i,
  input logic [NUM_Q-1:0]        full_i,
  input logic [NUM_Q-1:0]        q_pop_i,
  input logic [NUM_Q-1:0]        q_valid_i,
  input logic [NUM_Q*DATA_W-1:0] q_data_i,
  input logic                    irq_i
);
  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push_i)); // R3
  AST_HDR_NOT_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != 2'd2) |-> (push_i == '0)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i & full_i) == '0); // R7
  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(push_i[NUM_Q-1])); // R6
  AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_i) |-> $past(q_pop_i[NUM_Q-1])); // R6

  for (genvar g = 0; g < NUM_Q; g++) begin : g_hold
    AST_HEAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_valid_i[g] && !q_pop_i[g]) |=> (q_valid_i[g] && $stable(q_data_i[g*DATA_W +: DATA_W]))); // R9
  end
endmodule

bind tagged_rx_demux trdx_checker #(.NUM_Q(NUM_Q), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(parser_state), .push_i(push),
  .full_i(full), .q_pop_i(q_pop_i), .q_valid_i(q_valid_o), .q_data_i(q_data_o),
  .irq_i(irq_o)
);

// File: tb/tb_tagged_rx_demux.sv
module tb_tagged_rx_demux;
  localparam int NQ = 5;
  localparam int CATCH = 4;
  localparam int DEPTH = 25;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic tag_we = 1'b0;
  logic [1:0] tag_sel = '0;
  logic [31:0] tag_wdata = '0;
  logic [NQ-1:0] q_pop = '0;
  logic [NQ*32-1:0] q_data;
  logic [NQ-1:0] q_valid;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tagged_rx_demux dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .tag_we_i(tag_we), .tag_sel_i(tag_sel),
    .tag_wdata_i(tag_wdata), .q_pop_i(q_pop), .q_data_o(q_data),
    .q_valid_o(q_valid), .irq_o(irq)
  );

  typedef struct packed {
    logic [31:0] tag;
    logic [7:0]  len;
    logic [2:0]  q;
  } vec_t;

  localparam logic [31:0] T0 = 32'h0001_0203;
  localparam logic [31:0] T1 = 32'h0002_0305;
  localparam logic [31:0] T2 = 32'h00A0_1107;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{T0,            8'd3, 3'd0},  // R3 hit
    '{T1,            8'd2, 3'd1},  // R4 dup in tag 3
    '{T2,            8'd4, 3'd2},  // R3 hit
    '{32'h0001_0204, 8'd2, 3'd4},  // R5 type differs
    '{32'h0001_0303, 8'd1, 3'd4},  // R5 stream differs
    '{32'h0003_0203, 8'd2, 3'd4},  // R5 sender differs
    '{T0,            8'd1, 3'd0},  // R3
    '{32'h1234_5678, 8'd5, 3'd4}   // R5
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic send_word(input logic [31:0] w);
    in_data = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_pkt(input logic [31:0] tag, input logic [7:0] len, input logic [31:0] base);
    send_word({24'hC0DE5A, len});
    send_word(tag);
    for (int k = 0; k < int'(len); k++) send_word(base + 32'(k));
  endtask

  task automatic pop_check(input int q, input logic [31:0] exp, input string req);
    chk(q_valid[q] == 1'b1, req, 32'(q_valid[q]), 32'd1);
    chk(q_data[q*32 +: 32] == exp, req, q_data[q*32 +: 32], exp);
    q_pop[q] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    q_pop[q] = 1'b0;
  endtask

  task automatic write_tag(input logic [1:0] sel, input logic [31:0] v);
    tag_we = 1'b1;
    tag_sel = sel;
    tag_wdata = v;
    @(posedge clk);
    @(negedge clk);
    tag_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(in_ready == 1'b1, "R1 ready", 32'(in_ready), 32'd1);
    chk(q_valid == '0, "R1 valid", 32'(q_valid), 32'd0);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 32'd0);
    // R1 tags reset to zero: tag word 0 goes to queue 0
    send_pkt(32'h0, 8'd1, 32'h5555_0000);
    chk(q_valid == 5'b00001, "R1 zero tag", 32'(q_valid), 32'h1);
    pop_check(0, 32'h5555_0000, "R1 zero tag data");

    // R8 program tags, tag 3 duplicates tag 1
    write_tag(2'd0, T0);
    write_tag(2'd1, T1);
    write_tag(2'd2, T2);
    write_tag(2'd3, T1);

    // table walk: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      logic [31:0] base;
      base = 32'hA000_0000 + 32'(i << 8);
      send_pkt(VECS[i].tag, VECS[i].len, base);
      chk(q_valid == (5'b1 << VECS[i].q), "R3/R4/R5 route", 32'(q_valid), 32'(5'b1 << VECS[i].q));
      if (VECS[i].q == 3'(CATCH))
        chk(irq == 1'b1, "R6 irq set", 32'(irq), 32'd1);
      else
        chk(irq == 1'b0, "R6 irq quiet", 32'(irq), 32'd0);
      for (int k = 0; k < int'(VECS[i].len); k++)
        pop_check(int'(VECS[i].q), base + 32'(k), "R2/R9 payload order");
      chk(q_valid == '0, "R2 nothing extra stored", 32'(q_valid), 32'd0);
      chk(irq == 1'b0, "R6 irq cleared", 32'(irq), 32'd0);
    end

    // R8 rewrite tag 3 and route to queue 3
    write_tag(2'd3, 32'h0BAD_0001);
    send_pkt(32'h0BAD_0001, 8'd2, 32'hB300_0000);
    chk(q_valid == 5'b01000, "R8 new tag", 32'(q_valid), 32'h8);
    pop_check(3, 32'hB300_0000, "R8 data");
    pop_check(3, 32'hB300_0001, "R8 data");

    // R10 zero-length miss
    send_pkt(32'hFFFF_FFFF, 8'd0, 32'h0);
    chk(q_valid == '0, "R10 empty", 32'(q_valid), 32'd0);
    chk(irq == 1'b0, "R10 no irq", 32'(irq), 32'd0);
    chk(in_ready == 1'b1, "R10 back to header", 32'(in_ready), 32'd1);

    // R7 overflow stall: 26 words into a 25-word queue
    send_word({24'h0, 8'd26});
    send_word(T0);
    for (int k = 0; k < DEPTH; k++) send_word(32'hC000_0000 + 32'(k));
    in_data = 32'hC000_0000 + 32'(DEPTH);
    in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk(in_ready == 1'b0, "R7 stall", 32'(in_ready), 32'd0);
      @(negedge clk);
    end
    pop_check(0, 32'hC000_0000, "R7 head");
    chk(in_ready == 1'b1, "R7 resume", 32'(in_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 1; k <= DEPTH; k++) pop_check(0, 32'hC000_0000 + 32'(k), "R7 no loss");
    chk(q_valid == '0, "R7 drained", 32'(q_valid), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule